// File: doc/BRIEF.md
# Flipped-Pattern Multisample Resolve

This unit turns a raster-ordered stream of border samples into anti-aliased pixels. Each pixel contributes two RGB565 samples: one on its left border and one on its top border. The final colour of a pixel is the equal-weight mean of four samples:

- its own left and top samples;
- the left sample of the pixel to its right, which serves as its right sample;
- the top sample of the pixel below, which serves as its bottom sample.

The sample layout is mirrored on alternate pixels. As a result, the four samples of any pixel occupy distinct rows and distinct columns, and neighbours share border samples. Coverage therefore resolves in steps of a quarter.

The stream is organised in rows and frames. After the last pixel of a row, the unit raises a request. It then takes one extra sample on a separate edge input, which becomes the right sample of that row's last pixel. After the last row, the same edge input supplies one bottom sample per column for the bottom row. A one-row line buffer keeps three-sample partial sums for each column, so each pixel leaves one row after its own samples arrived. For the pixel about to be accepted, the unit also reports the four sub-sample offsets in thirds of a pixel, for use by a rasterizer.

Top module: `fq_resolve`

## Requirements
- R1: After reset, `res_valid` and `edge_req` are low. `pos_offs` reports the layout of pixel (0,0), which has even parity.
- R2: A pixel beat in row 0 produces no result. A pixel beat at column x of row y>0 produces the result of pixel (x,y-1), with `res_valid` high in the cycle after the accepting clock edge. In all other cycles `res_valid` is low.
- R3: A result colour is computed per channel, on red [15:11], green [10:5] and blue [4:0]. Each channel equals (left + top + right + bottom + 2) >> 2, where right is the left sample of pixel (x+1,y) and bottom is the top sample of pixel (x,y+1).
- R4: For the last column (x = WIDTH-1), the right sample is the edge-input sample accepted after that row's pixels.
- R5: For the bottom row, the bottom sample of column x is the x-th edge-input beat after the last row's right-edge beat. The result is reported with `res_y` = HEIGHT-1, one cycle after that beat.
- R6: `edge_req` rises after the WIDTH-th pixel beat of a row. It falls after one edge beat, unless that row is the last one. In that case it stays high for WIDTH further edge beats, after which the next frame starts at (0,0).
- R7: `pix_valid` is ignored while `edge_req` is high, and `edg_valid` is ignored while it is low. Neither changes the position or produces a result.
- R8: `res_x` and `res_y` give the column and row of the resolved pixel.
- R9: `pos_offs` packs {Lx,Ly,Tx,Ty,Rx,Ry,Bx,By}, two bits each in thirds, with Lx at [15:14]. For an even (x+y) pixel it is L(0,1) T(2,0) R(3,2) B(1,3). For an odd pixel it is L(0,2) T(1,0) R(3,1) B(2,3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel beat present |
| pix_left | input | 16 | Left-border sample, RGB565 |
| pix_top | input | 16 | Top-border sample, RGB565 |
| edg_valid | input | 1 | Edge beat present |
| edg_smp | input | 16 | Right-edge or bottom-edge sample, RGB565 |
| edge_req | output | 1 | Unit expects edge beats |
| pos_offs | output | 16 | Sub-sample offsets of the next pixel, in thirds |
| res_valid | output | 1 | Resolved pixel present |
| res_rgb | output | 16 | Resolved colour, RGB565 |
| res_x | output | XW | Resolved pixel column |
| res_y | output | YW | Resolved pixel row |

## Verification
The hardest cases to reach are the two frame boundaries. One is the last-column pixel, whose right sample arrives on a different input after the row. The other is the bottom row, which is resolved only once the frame has ended. To reach them, the stimulus runs complete frames on a small screen and compares every cycle against a behavioural model. Within those frames it places unwanted beats on the inactive input at mid-row, at row end and between frames. Three colour sets are used: pseudo-random, all-white for channel saturation, and a checkerboard that lands exactly on the rounding midpoint.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int unsigned NCH      = 3;
  localparam int unsigned PIX_BITS = 16;
  // channel order: red, green, blue
  localparam int unsigned CH_W   [NCH] = '{5, 6, 5};
  localparam int unsigned CH_LSB [NCH] = '{11, 5, 0};
  // partial sums of up to three samples need two extra bits
  localparam int unsigned PS_W   [NCH] = '{CH_W[0] + 2, CH_W[1] + 2, CH_W[2] + 2};
  localparam int unsigned PS_LSB [NCH] = '{PS_W[1] + PS_W[2], PS_W[2], 0};
  localparam int unsigned PS_BITS = PS_W[0] + PS_W[1] + PS_W[2];

  typedef enum logic [1:0] {
    PH_ROW  = 2'd0,
    PH_EDGE = 2'd1,
    PH_BOT  = 2'd2
  } phase_e;
endpackage

// File: rtl/fq_chan_sum.sv
module fq_chan_sum
  import fq_pkg::*;
(
  input  logic [PS_BITS-1:0]  ps_in,
  input  logic [PIX_BITS-1:0] smp,
  output logic [PS_BITS-1:0]  ps_out
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned CW = CH_W[c];
    localparam int unsigned PW = PS_W[c];
    localparam int unsigned CL = CH_LSB[c];
    localparam int unsigned PL = PS_LSB[c];
    assign ps_out[PL +: PW] = ps_in[PL +: PW] + {{(PW - CW){1'b0}}, smp[CL +: CW]};
  end
endmodule

// File: rtl/fq_round.sv
module fq_round
  import fq_pkg::*;
(
  input  logic [PS_BITS-1:0]  ps_in,
  input  logic [PIX_BITS-1:0] smp,
  output logic [PIX_BITS-1:0] rgb
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned CW = CH_W[c];
    localparam int unsigned PW = PS_W[c];
    localparam int unsigned CL = CH_LSB[c];
    localparam int unsigned PL = PS_LSB[c];
    logic [PW-1:0] tot;
    // four samples at most 4*(2^CW-1)+2, which fits in PW bits
    assign tot = ps_in[PL +: PW] + {{(PW - CW){1'b0}}, smp[CL +: CW]} + PW'(2);
    assign rgb[CL +: CW] = CW'(tot >> 2);
  end
endmodule

// File: rtl/fq_pattern.sv
module fq_pattern (
  input  logic        odd,
  output logic [15:0] offs
);
  logic [1:0] lx, ly, tx, ty, rx, ry, bx, by;

  always_comb begin
    lx = 2'd0;
    tx = odd ? 2'd1 : 2'd2;
    rx = 2'd3;
    bx = odd ? 2'd2 : 2'd1;
    ly = odd ? 2'd2 : 2'd1;
    ty = 2'd0;
    ry = odd ? 2'd1 : 2'd2;
    by = 2'd3;
    offs = {lx, ly, tx, ty, rx, ry, bx, by};
  end

  always_comb begin
    p_cols_unique_r9: assert (tx != bx && tx != lx && bx != rx);
    p_rows_unique_r9: assert (ly != ry && ly != ty && ry != by);
  end
endmodule

// File: rtl/fq_linebuf.sv
module fq_linebuf #(
  parameter int DEPTH = 176,
  parameter int DW    = 22,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr <= AW'(DEPTH - 1)));
  p_rd_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    raddr <= AW'(DEPTH - 1));
endmodule

// File: rtl/fq_seq.sv
module fq_seq
  import fq_pkg::*;
#(
  parameter int WIDTH  = 176,
  parameter int HEIGHT = 144,
  parameter int XW     = $clog2(WIDTH),
  parameter int YW     = $clog2(HEIGHT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          edg_valid,
  output phase_e        ph,
  output logic [XW-1:0] cx,
  output logic [YW-1:0] cy,
  output logic          acc,
  output logic          re,
  output logic          be
);
  localparam logic [XW-1:0] X_LAST = XW'(WIDTH - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(HEIGHT - 1);

  phase_e        ph_n;
  logic [XW-1:0] cx_n;
  logic [YW-1:0] cy_n;

  always_comb begin
    acc  = (ph == PH_ROW) && pix_valid;
    re   = (ph == PH_EDGE) && edg_valid;
    be   = (ph == PH_BOT) && edg_valid;
    ph_n = ph;
    cx_n = cx;
    cy_n = cy;
    if (acc) begin
      if (cx == X_LAST) begin
        cx_n = '0;
        ph_n = PH_EDGE;
      end else begin
        cx_n = cx + XW'(1);
      end
    end
    if (re) begin
      if (cy == Y_LAST) begin
        ph_n = PH_BOT;
      end else begin
        cy_n = cy + YW'(1);
        ph_n = PH_ROW;
      end
    end
    if (be) begin
      if (cx == X_LAST) begin
        cx_n = '0;
        cy_n = '0;
        ph_n = PH_ROW;
      end else begin
        cx_n = cx + XW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_ROW;
      cx <= '0;
      cy <= '0;
    end else begin
      ph <= ph_n;
      cx <= cx_n;
      cy <= cy_n;
    end
  end

  p_edge_after_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ROW && pix_valid && cx == X_LAST) |=> (ph == PH_EDGE));
  p_ignore_pix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_ROW && pix_valid && !edg_valid) |=> ($stable(cx) && $stable(cy) && $stable(ph)));
  p_ignore_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ROW && !pix_valid && edg_valid) |=> ($stable(cx) && $stable(cy) && ph == PH_ROW));
  p_col_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cx <= X_LAST);
endmodule

// File: rtl/fq_resolve.sv
module fq_resolve
  import fq_pkg::*;
#(
  parameter int WIDTH  = 176,
  parameter int HEIGHT = 144,
  parameter int XW     = $clog2(WIDTH),
  parameter int YW     = $clog2(HEIGHT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [15:0]   pix_left,
  input  logic [15:0]   pix_top,
  input  logic          edg_valid,
  input  logic [15:0]   edg_smp,
  output logic          edge_req,
  output logic [15:0]   pos_offs,
  output logic          res_valid,
  output logic [15:0]   res_rgb,
  output logic [XW-1:0] res_x,
  output logic [YW-1:0] res_y
);
  localparam logic [XW-1:0] X_LAST = XW'(WIDTH - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(HEIGHT - 1);

  phase_e        ph;
  logic [XW-1:0] cx;
  logic [YW-1:0] cy;
  logic          acc, re, be;

  fq_seq #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .XW(XW), .YW(YW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .edg_valid(edg_valid),
    .ph(ph), .cx(cx), .cy(cy), .acc(acc), .re(re), .be(be)
  );

  // sample steering
  logic [15:0] left_in, top_in;
  always_comb begin
    left_in = (ph == PH_EDGE) ? edg_smp : pix_left;
    top_in  = (ph == PH_BOT)  ? edg_smp : pix_top;
  end

  // own-pixel partial sum (left + top)
  logic [PS_BITS-1:0] ps_left, ps_own, hold_q, hold_n;
  fq_chan_sum u_sum_l (.ps_in('0),     .smp(pix_left), .ps_out(ps_left));
  fq_chan_sum u_sum_t (.ps_in(ps_left), .smp(pix_top), .ps_out(ps_own));

  // previous pixel plus its right neighbour's left sample
  logic [PS_BITS-1:0] wr_data, rd_data;
  fq_chan_sum u_sum_r (.ps_in(hold_q), .smp(left_in), .ps_out(wr_data));

  logic          wr_en;
  logic [XW-1:0] wr_addr;
  always_comb begin
    wr_en   = (acc && cx != '0) || re;
    wr_addr = re ? X_LAST : (cx - XW'(1));
    hold_n  = acc ? ps_own : hold_q;
  end

  fq_linebuf #(.DEPTH(WIDTH), .DW(PS_BITS), .AW(XW)) u_lb (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(cx), .rdata(rd_data)
  );

  logic [15:0] rgb_n;
  fq_round u_rnd (.ps_in(rd_data), .smp(top_in), .rgb(rgb_n));

  fq_pattern u_pat (.odd(cx[0] ^ cy[0]), .offs(pos_offs));

  // output stage
  logic          resolve;
  logic          vld_n;
  logic [15:0]   rgb_q_n;
  logic [XW-1:0] x_n;
  logic [YW-1:0] y_n;

  always_comb begin
    resolve = (acc && cy != '0) || be;
    vld_n   = resolve;
    rgb_q_n = resolve ? rgb_n : res_rgb;
    x_n     = resolve ? cx : res_x;
    y_n     = res_y;
    if (resolve) begin
      y_n = be ? Y_LAST : (cy - YW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      res_valid <= 1'b0;
      res_rgb   <= '0;
      res_x     <= '0;
      res_y     <= '0;
    end else begin
      hold_q    <= hold_n;
      res_valid <= vld_n;
      res_rgb   <= rgb_q_n;
      res_x     <= x_n;
      res_y     <= y_n;
    end
  end

  assign edge_req = (ph != PH_ROW);

  p_row0_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_req && pix_valid && cy == '0) |=> !res_valid);
  p_bottom_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_req && edg_valid && ph == PH_BOT) |=> (res_valid && res_y == Y_LAST));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !edg_valid) |=> !res_valid);
  p_coord_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_req && pix_valid && cy != '0) |=> (res_x == $past(cx)));
endmodule

// File: tb/sim_fq_resolve.sv
module sim_fq_resolve;
  localparam int BW = 5;
  localparam int BH = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_valid, edg_valid;
  logic [15:0] pix_left, pix_top, edg_smp;
  logic        edge_req, res_valid;
  logic [15:0] pos_offs, res_rgb;
  logic [2:0]  res_x;
  logic [1:0]  res_y;

  int vectors = 0;
  int fails   = 0;

  logic [15:0] lq [BH][BW];
  logic [15:0] tq [BH][BW];
  logic [15:0] rq [BH];
  logic [15:0] bq [BW];

  always #2 clk = ~clk;

  fq_resolve #(.WIDTH(BW), .HEIGHT(BH)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_left(pix_left),
    .pix_top(pix_top), .edg_valid(edg_valid), .edg_smp(edg_smp),
    .edge_req(edge_req), .pos_offs(pos_offs), .res_valid(res_valid),
    .res_rgb(res_rgb), .res_x(res_x), .res_y(res_y)
  );

  function automatic logic [15:0] avg4(input logic [15:0] a, b, c, d);
    int r, g, bl;
    r  = (int'(a[15:11]) + int'(b[15:11]) + int'(c[15:11]) + int'(d[15:11]) + 2) / 4;
    g  = (int'(a[10:5])  + int'(b[10:5])  + int'(c[10:5])  + int'(d[10:5])  + 2) / 4;
    bl = (int'(a[4:0])   + int'(b[4:0])   + int'(c[4:0])   + int'(d[4:0])   + 2) / 4;
    return {r[4:0], g[5:0], bl[4:0]};
  endfunction

  function automatic logic [15:0] exp_pos(input int x, input int y);
    if (((x + y) % 2) == 0) return {2'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd2, 2'd1, 2'd3};
    else                    return {2'd0, 2'd2, 2'd1, 2'd0, 2'd3, 2'd1, 2'd2, 2'd3};
  endfunction

  task automatic check(input string req, input string what, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic beat(input logic pv, input logic [15:0] pl, input logic [15:0] pt,
                      input logic ev, input logic [15:0] es,
                      input logic xv, input logic [15:0] xrgb, input int xx, input int xy,
                      input logic xedge, input string req);
    pix_valid = pv; pix_left = pl; pix_top = pt;
    edg_valid = ev; edg_smp = es;
    @(posedge clk);
    @(negedge clk);
    check(req, "res_valid", int'(res_valid), int'(xv));
    if (xv) begin
      check(req, "res_rgb", int'(res_rgb), int'(xrgb));
      check("R8", "res_x", int'(res_x), xx);
      check("R8", "res_y", int'(res_y), xy);
    end
    check("R6", "edge_req", int'(edge_req), int'(xedge));
    pix_valid = 1'b0; edg_valid = 1'b0;
  endtask

  task automatic fill(input int kind);
    for (int y = 0; y < BH; y++) begin
      for (int x = 0; x < BW; x++) begin
        case (kind)
          0: begin lq[y][x] = 16'($urandom); tq[y][x] = 16'($urandom); end
          1: begin lq[y][x] = 16'hFFFF; tq[y][x] = 16'hFFFF; end
          default: begin
            lq[y][x] = ((x + y) % 2 == 0) ? 16'hFFFF : 16'h0000;
            tq[y][x] = ((x + y) % 2 == 0) ? 16'h0000 : 16'hFFFF;
          end
        endcase
      end
      rq[y] = (kind == 0) ? 16'($urandom) : ((kind == 1) ? 16'hFFFF : 16'h0000);
    end
    for (int x = 0; x < BW; x++)
      bq[x] = (kind == 0) ? 16'($urandom) : ((kind == 1) ? 16'hFFFF : ((x % 2 == 0) ? 16'hFFFF : 16'h0000));
  endtask

  function automatic logic [15:0] right_of(input int x, input int y);
    return (x + 1 < BW) ? lq[y][x + 1] : rq[y];
  endfunction

  task automatic run_frame();
    for (int y = 0; y < BH; y++) begin
      for (int x = 0; x < BW; x++) begin
        logic [15:0] e;
        if (x == 2) begin
          // stray edge beat mid-row: ignored (R7)
          beat(1'b0, 16'h0, 16'h0, 1'b1, 16'hA5A5, 1'b0, 16'h0, 0, 0, 1'b0, "R7");
        end
        check("R9", "pos_offs", int'(pos_offs), int'(exp_pos(x, y)));
        e = 16'h0;
        if (y > 0) e = avg4(lq[y-1][x], tq[y-1][x], right_of(x, y - 1), tq[y][x]);
        beat(1'b1, lq[y][x], tq[y][x], 1'b0, 16'h0, (y > 0), e, x, y - 1,
             (x == BW - 1), (x == BW - 1) ? "R4" : ((y > 0) ? "R3" : "R2"));
      end
      // stray pixel beat while the edge is requested: ignored (R7)
      beat(1'b1, 16'h1234, 16'h4321, 1'b0, 16'h0, 1'b0, 16'h0, 0, 0, 1'b1, "R7");
      beat(1'b0, 16'h0, 16'h0, 1'b1, rq[y], 1'b0, 16'h0, 0, 0, (y == BH - 1), "R6");
    end
    for (int x = 0; x < BW; x++) begin
      if (x == 1) beat(1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0, 1'b0, 16'h0, 0, 0, 1'b1, "R7");
      beat(1'b0, 16'h0, 16'h0, 1'b1, bq[x], 1'b1,
           avg4(lq[BH-1][x], tq[BH-1][x], right_of(x, BH - 1), bq[x]),
           x, BH - 1, (x != BW - 1), "R5");
    end
    // idle cycle between frames
    beat(1'b0, 16'h0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 0, 0, 1'b0, "R2");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pix_valid = 1'b0; edg_valid = 1'b0;
    pix_left = '0; pix_top = '0; edg_smp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "res_valid", int'(res_valid), 0);
    check("R1", "edge_req", int'(edge_req), 0);
    check("R1", "pos_offs", int'(pos_offs), int'(exp_pos(0, 0)));
    fill(0); run_frame();
    fill(1); run_frame();
    fill(2); run_frame();
    fill(0); run_frame();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule